// File: doc/BRIEF.md
# Internal Data Operand Address Resolver

This block turns an operand specifier into a concrete access inside the on-chip data space of a small 8-bit processor. A request carries an addressing-mode code, an 8-bit operand field and the 2-bit register bank select. The block works out whether the operand lives in the internal data RAM or in the special-function register (SFR) area. It performs the read, and an optional write, at that target. It then reports the resolved address, a one-hot target flag and the value that was read.

The same 8-bit number can land in different places depending on the mode. In direct mode, an address with the top bit set names an SFR. In register-indirect mode, the same value names a byte of the upper internal RAM. The block holds the 256-byte internal RAM itself, so that indirect requests can fetch their pointer from R0 or R1 of the current bank. It also holds a small SFR file with the accumulator, the B register and the stack pointer.

Register and direct requests answer one cycle after they are accepted. Indirect requests take one extra cycle: the first cycle fetches the pointer, and the second cycle accesses the byte that the pointer names.

Top module: `idata_addr_resolver`

## Requirements
- R1: After reset, resp_valid and busy are 0. Direct reads of the accumulator (0xE0), B (0xF0) and stack pointer (0x81) return 0x00, 0x00 and 0x07.
- R2: Register mode (req_mode 2'b00) uses req_field[2:0] as the register number n. The response comes one cycle after acceptance and targets RAM at address bank_sel*8 + n.
- R3: Direct mode (req_mode 2'b01) with req_field below 0x80 targets RAM at address req_field, with a one-cycle response.
- R4: Direct mode with req_field of 0x80 or above targets the SFR area at address req_field, with a one-cycle response.
- R5: Indirect mode (req_mode 2'b10) reads a pointer from R0 (req_field[0]=0) or R1 (req_field[0]=1) of the current bank. The response comes two cycles after acceptance and targets RAM at the pointer value, over the full range 0x00 to 0xFF.
- R6: busy is 1 for exactly the one cycle between accepting an indirect request and its response. A request presented while busy is 1 is ignored and has no effect.
- R7: While resp_valid is 1, exactly one of resp_is_ram and resp_is_sfr is 1. While resp_valid is 0, both are 0.
- R8: With wr_en set, wr_data is stored at the resolved target. rd_data reports the target's contents from before that write.
- R9: The accumulator, B and stack pointer can be written and read back at 0xE0, 0xF0 and 0x81.
- R10: An SFR address with no register behind it reads as 0x00, and writes to it are discarded. They do not reach the RAM byte at the same address.
- R11: Mode code 2'b11 is reserved. Such a request gives no response, sets no busy and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing mode: 00 register, 01 direct, 10 indirect, 11 reserved |
| req_field | input | 8 | Operand field: register number, pointer select or address |
| bank_sel | input | 2 | Current register bank |
| wr_en | input | 1 | Write wr_data to the resolved target |
| wr_data | input | 8 | Write value |
| busy | output | 1 | Indirect pointer fetch in progress; requests ignored |
| resp_valid | output | 1 | Resolved access completed last edge |
| resp_is_ram | output | 1 | Response targets internal RAM |
| resp_is_sfr | output | 1 | Response targets the SFR area |
| resp_addr | output | 8 | Resolved physical address |
| rd_data | output | 8 | Target contents before any write |

## Verification
Register mode is swept over all four banks and all eight register numbers. This separates the bank contribution from the register index in the resolved address. Direct mode is swept over all 256 addresses, first as writes and then as reads, which exposes any misplaced boundary between RAM and SFR. Indirect mode is swept over every pointer value from both R0 and R1 in rotating banks, and the results are then compared against bytes that direct SFR writes at the same numbers must not have touched; this is what tells the two maps of the upper half apart. Separate cases present a request while busy is set and a request with the reserved mode, and then read the accumulator back to show nothing changed.

// File: rtl/idr_pkg.sv
package idr_pkg;

    typedef enum logic [1:0] {
        MODE_REG = 2'b00,
        MODE_DIR = 2'b01,
        MODE_IND = 2'b10,
        MODE_RSV = 2'b11
    } op_mode_e;

endpackage

// File: rtl/idr_target_map.sv
module idr_target_map
    import idr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned IDX_W  = 3
) (
    input  op_mode_e            mode,
    input  logic [ADDR_W-1:0]   field,
    input  logic [BANK_W-1:0]   bank,
    output logic                hit,
    output logic                indirect,
    output logic                to_sfr,
    output logic [ADDR_W-1:0]   tgt_addr,
    output logic [ADDR_W-1:0]   ptr_addr
);

    logic [ADDR_W-1:0] reg_addr;

    // bank base plus register number; indirect pointers live in R0/R1
    always_comb begin
        reg_addr = ADDR_W'({bank, field[IDX_W-1:0]});
        ptr_addr = ADDR_W'({bank, IDX_W'(field[0])});
    end

    always_comb begin
        hit      = 1'b0;
        indirect = 1'b0;
        to_sfr   = 1'b0;
        tgt_addr = '0;
        unique case (mode)
            MODE_REG: begin
                hit      = 1'b1;
                tgt_addr = reg_addr;
            end
            MODE_DIR: begin
                hit      = 1'b1;
                to_sfr   = field[ADDR_W-1];
                tgt_addr = field;
            end
            MODE_IND: begin
                hit      = 1'b1;
                indirect = 1'b1;
            end
            default: begin
                hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idr_data_ram.sv
module idr_data_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic [DATA_W-1:0] ptr_data,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[acc_addr] <= wdata;
        end
    end

    assign ptr_data = mem_q[ptr_addr];
    assign acc_data = mem_q[acc_addr];

endmodule

// File: rtl/idr_sfr_file.sv
module idr_sfr_file #(
    parameter int unsigned        ADDR_W  = 8,
    parameter int unsigned        DATA_W  = 8,
    parameter logic [ADDR_W-1:0]  A_ADDR  = 8'hE0,
    parameter logic [ADDR_W-1:0]  B_ADDR  = 8'hF0,
    parameter logic [ADDR_W-1:0]  SP_ADDR = 8'h81,
    parameter logic [DATA_W-1:0]  A_RST   = 8'h00,
    parameter logic [DATA_W-1:0]  B_RST   = 8'h00,
    parameter logic [DATA_W-1:0]  SP_RST  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] breg;
        logic [DATA_W-1:0] sp;
    } sfr_t;

    sfr_t sfr_d, sfr_q;

    always_comb begin
        sfr_d = sfr_q;
        if (we) begin
            if (addr == A_ADDR)  sfr_d.acc  = wdata;
            if (addr == B_ADDR)  sfr_d.breg = wdata;
            if (addr == SP_ADDR) sfr_d.sp   = wdata;
        end
        // unmapped SFR addresses read as zero
        if (addr == A_ADDR)       rdata = sfr_q.acc;
        else if (addr == B_ADDR)  rdata = sfr_q.breg;
        else if (addr == SP_ADDR) rdata = sfr_q.sp;
        else                      rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sfr_q <= '{acc: A_RST, breg: B_RST, sp: SP_RST};
        end else begin
            sfr_q <= sfr_d;
        end
    end

endmodule

// File: rtl/idata_addr_resolver.sv
module idata_addr_resolver
    import idr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_field,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_is_ram,
    output logic              resp_is_sfr,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              pend;
        logic              pend_we;
        logic [DATA_W-1:0] pend_wd;
        logic [ADDR_W-1:0] ptr;
        logic              rvalid;
        logic              rsfr;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic              map_hit, map_ind, map_sfr;
    logic [ADDR_W-1:0] map_addr, map_ptr;
    logic [DATA_W-1:0] ptr_val, ram_rd, sfr_rd;
    logic              accept, acc_go, acc_sfr, acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wd;

    idr_target_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W)
    ) u_map (
        .mode     (op_mode_e'(req_mode)),
        .field    (req_field),
        .bank     (bank_sel),
        .hit      (map_hit),
        .indirect (map_ind),
        .to_sfr   (map_sfr),
        .tgt_addr (map_addr),
        .ptr_addr (map_ptr)
    );

    idr_data_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk      (clk),
        .ptr_addr (map_ptr),
        .ptr_data (ptr_val),
        .acc_addr (acc_addr),
        .acc_data (ram_rd),
        .we       (acc_go & acc_we & ~acc_sfr),
        .wdata    (acc_wd)
    );

    idr_sfr_file #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sfr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_go & acc_we & acc_sfr),
        .addr  (acc_addr),
        .wdata (acc_wd),
        .rdata (sfr_rd)
    );

    always_comb begin
        st_d   = st_q;
        accept = req_valid & ~st_q.pend;

        // second phase of an indirect access takes priority over new work
        if (st_q.pend) begin
            acc_go   = 1'b1;
            acc_sfr  = 1'b0;
            acc_addr = st_q.ptr;
            acc_we   = st_q.pend_we;
            acc_wd   = st_q.pend_wd;
        end else begin
            acc_go   = accept & map_hit & ~map_ind;
            acc_sfr  = map_sfr;
            acc_addr = map_addr;
            acc_we   = wr_en;
            acc_wd   = wr_data;
        end

        st_d.pend = accept & map_hit & map_ind;
        if (accept & map_hit & map_ind) begin
            st_d.ptr     = ptr_val;
            st_d.pend_we = wr_en;
            st_d.pend_wd = wr_data;
        end

        st_d.rvalid = acc_go;
        if (acc_go) begin
            st_d.rsfr  = acc_sfr;
            st_d.raddr = acc_addr;
            st_d.rdata = acc_sfr ? sfr_rd : ram_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.pend;
    assign resp_valid  = st_q.rvalid;
    assign resp_is_ram = st_q.rvalid & ~st_q.rsfr;
    assign resp_is_sfr = st_q.rvalid & st_q.rsfr;
    assign resp_addr   = st_q.raddr;
    assign rd_data     = st_q.rdata;

endmodule

// File: rtl/idr_checks.sv
module idr_checks #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic [ADDR_W-1:0] req_field,
    input logic [BANK_W-1:0] bank_sel,
    input logic              busy,
    input logic              resp_valid,
    input logic              resp_is_ram,
    input logic              resp_is_sfr,
    input logic [ADDR_W-1:0] resp_addr
);

    logic take;
    assign take = req_valid && !busy;

    p_reg_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_mode == 2'b00) |=> (resp_valid && resp_is_ram && !busy
            && resp_addr[IDX_W-1:0] == $past(req_field[IDX_W-1:0])
            && resp_addr[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'($past(bank_sel))));

    p_direct_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_mode == 2'b01 && !req_field[ADDR_W-1])
            |=> (resp_valid && resp_is_ram && resp_addr == $past(req_field)));

    p_sfr_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_is_sfr |-> resp_addr[ADDR_W-1]);

    p_ind_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_mode == 2'b10) |=> (busy && !resp_valid));

    p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && resp_valid && resp_is_ram));

    p_target_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones({resp_is_ram, resp_is_sfr}) == 1);

    p_target_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(resp_is_ram || resp_is_sfr));

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_mode == 2'b11) |=> (!resp_valid && !busy));

endmodule

bind idata_addr_resolver idr_checks #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .req_field   (req_field),
    .bank_sel    (bank_sel),
    .busy        (busy),
    .resp_valid  (resp_valid),
    .resp_is_ram (resp_is_ram),
    .resp_is_sfr (resp_is_sfr),
    .resp_addr   (resp_addr)
);

// File: tb/sim_idata_addr_resolver.sv
module sim_idata_addr_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'b00;
    logic [7:0] req_field = 8'h00;
    logic [1:0] bank_sel = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy, resp_valid, resp_is_ram, resp_is_sfr;
    logic [7:0] resp_addr, rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [7:0] model [256];
    bit         known [256];
    logic [7:0] m_acc = 8'h00, m_b = 8'h00, m_sp = 8'h07;

    always #(CLK_PERIOD/2) clk = ~clk;

    idata_addr_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_field(req_field), .bank_sel(bank_sel), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .resp_valid(resp_valid), .resp_is_ram(resp_is_ram),
        .resp_is_sfr(resp_is_sfr), .resp_addr(resp_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sfr_val(input logic [7:0] a);
        if (a == 8'hE0) return m_acc;
        if (a == 8'hF0) return m_b;
        if (a == 8'h81) return m_sp;
        return 8'h00;
    endfunction

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'hE0) m_acc = v;
        if (a == 8'hF0) m_b = v;
        if (a == 8'h81) m_sp = v;
    endtask

    // one request; checks the response against the model, then updates it
    task automatic issue(input string tag, input logic [1:0] m, input logic [7:0] f,
                         input logic [1:0] bk, input logic we, input logic [7:0] wd,
                         input bit intrude);
        logic [7:0] e_addr;
        bit         e_sfr;
        logic [7:0] e_rd;
        bit         e_known;
        if (m == 2'b00) begin
            e_addr = {3'b000, bk, f[2:0]};
            e_sfr  = 1'b0;
        end else if (m == 2'b01) begin
            e_addr = f;
            e_sfr  = f[7];
        end else begin
            e_addr = model[{3'b000, bk, 2'b00, f[0]}];
            e_sfr  = 1'b0;
        end
        e_rd    = e_sfr ? sfr_val(e_addr) : model[e_addr];
        e_known = e_sfr ? 1'b1 : known[e_addr];
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_field = f; bank_sel = bk;
        wr_en = we; wr_data = wd;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        if (m == 2'b10) begin
            chk({tag, " R6 busy during fetch"}, int'(busy), 1);
            chk({tag, " R5 no early response"}, int'(resp_valid), 0);
            if (intrude) begin
                req_valid = 1'b1; req_mode = 2'b01; req_field = 8'hE0;
                wr_en = 1'b1; wr_data = ~m_acc;
            end
            @(negedge clk);
            req_valid = 1'b0; wr_en = 1'b0;
            chk({tag, " R6 busy drops"}, int'(busy), 0);
        end
        chk({tag, " R7 resp_valid"}, int'(resp_valid), 1);
        chk({tag, " R7 is_ram"}, int'(resp_is_ram), int'(!e_sfr));
        chk({tag, " R7 is_sfr"}, int'(resp_is_sfr), int'(e_sfr));
        chk({tag, " addr"}, int'(resp_addr), int'(e_addr));
        if (e_known) chk({tag, " R8 rd_data"}, int'(rd_data), int'(e_rd));
        if (we) begin
            if (e_sfr) sfr_write(e_addr, wd);
            else begin
                model[e_addr] = wd;
                known[e_addr] = 1'b1;
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i] = 8'h00;
            known[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 resp_valid in reset", int'(resp_valid), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 resp_valid after reset", int'(resp_valid), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R7 no target after reset", int'(resp_is_ram | resp_is_sfr), 0);
        issue("R1 acc reset", 2'b01, 8'hE0, 2'b00, 1'b0, 8'h00, 1'b0);
        chk("R1 acc value", int'(rd_data), 8'h00);
        issue("R1 b reset", 2'b01, 8'hF0, 2'b00, 1'b0, 8'h00, 1'b0);
        chk("R1 b value", int'(rd_data), 8'h00);
        issue("R1 sp reset", 2'b01, 8'h81, 2'b00, 1'b0, 8'h00, 1'b0);
        chk("R1 sp value", int'(rd_data), 8'h07);

        // R2: every bank and register number
        for (int bk = 0; bk < 4; bk++)
            for (int n = 0; n < 8; n++)
                issue("R2 reg write", 2'b00, 8'(n), 2'(bk), 1'b1, 8'(bk*37 + n*11 + 3), 1'b0);
        for (int bk = 0; bk < 4; bk++)
            for (int n = 0; n < 8; n++)
                issue("R2 reg read", 2'b00, 8'(n) | 8'hF8, 2'(bk), 1'b0, 8'h00, 1'b0);

        // R3: direct writes over the whole lower half
        for (int a = 0; a < 128; a++)
            issue("R3 direct write", 2'b01, 8'(a), 2'(a % 4), 1'b1, 8'(a ^ 8'h5A), 1'b0);

        // R5: indirect writes reach every byte
        for (int p = 0; p < 256; p++) begin
            issue("R5 set pointer", 2'b00, 8'(p % 2), 2'(p / 2 % 4), 1'b1, 8'(p), 1'b0);
            issue("R5 indirect write", 2'b10, 8'(p % 2), 2'(p / 2 % 4), 1'b1, 8'(p*7 + 1), 1'b0);
        end

        // R4/R9/R10: direct sweep of the SFR area, write then read back
        for (int a = 128; a < 256; a++)
            issue("R4 sfr write", 2'b01, 8'(a), 2'b00, 1'b1, 8'(a ^ 8'h3C), 1'b0);
        for (int a = 128; a < 256; a++) begin
            issue("R4 sfr read", 2'b01, 8'(a), 2'b00, 1'b0, 8'h00, 1'b0);
            if (a == 8'hE0 || a == 8'hF0 || a == 8'h81)
                chk("R9 implemented sfr", int'(rd_data), a ^ 8'h3C);
            else
                chk("R10 unmapped sfr reads zero", int'(rd_data), 0);
        end

        // R5/R10: indirect reads; upper RAM must hold indirect data, not SFR writes
        for (int p = 0; p < 256; p++) begin
            issue("R5 set pointer", 2'b00, 8'(p % 2), 2'((p + 1) % 4), 1'b1, 8'(p), 1'b0);
            issue("R5 indirect read", 2'b10, 8'(p % 2), 2'((p + 1) % 4), 1'b0, 8'h00, 1'b0);
            if (p >= 128)
                chk("R10 upper ram untouched by sfr write", int'(rd_data), int'(model[p]));
        end

        // R3: direct reads of lower half
        for (int a = 0; a < 128; a++)
            issue("R3 direct read", 2'b01, 8'(a), 2'b11, 1'b0, 8'h00, 1'b0);

        // R6: request during busy is ignored
        issue("R9 acc set", 2'b01, 8'hE0, 2'b00, 1'b1, 8'h12, 1'b0);
        issue("R6 set pointer", 2'b00, 8'h01, 2'b10, 1'b1, 8'h40, 1'b0);
        issue("R6 indirect with intruder", 2'b10, 8'h01, 2'b10, 1'b0, 8'h00, 1'b1);
        @(negedge clk);
        chk("R6 intruder gives no response", int'(resp_valid), 0);
        issue("R6 acc after intruder", 2'b01, 8'hE0, 2'b00, 1'b0, 8'h00, 1'b0);
        chk("R6 acc unchanged", int'(rd_data), 8'h12);

        // R11: reserved mode
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'b11; req_field = 8'hE0; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk("R11 no response", int'(resp_valid), 0);
        chk("R11 no busy", int'(busy), 0);
        @(negedge clk);
        chk("R11 still no response", int'(resp_valid), 0);
        issue("R11 acc after reserved", 2'b01, 8'hE0, 2'b00, 1'b0, 8'h00, 1'b0);
        chk("R11 acc unchanged", int'(rd_data), 8'h12);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule